// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor

This block is a small 16-bit processor built around one working register, the accumulator. Program and data share a single word-addressed memory that the processor reaches through one synchronous port. Each instruction word carries a 4-bit operation code in its top bits and a 12-bit word address in the rest. The processor steps through a short sequence of states for every instruction: it fetches the word, latches it and advances the program counter, then either touches memory, redirects the program counter, or stops.

The block fits where a tiny sequencer must run a fixed routine out of a shared RAM, for example a boot-time setup routine or a test pattern engine. The surrounding logic supplies the memory and watches the halted output to learn when the routine has finished. Reset restarts execution from word 0.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. The accumulator and program counter clear to zero, so a program starting with a store at word 0 writes 0.
- R2: An instruction word splits into operation code bits 15:12 and operand address bits 11:0. Every one of the 4096 word addresses, including 0xFFF, can be used as an operand.
- R3: The program counter points at the next instruction. It advances by one per instruction unless a jump is taken.
- R4: Code 0 copies mem[S] into the accumulator. Code 2 adds mem[S] to it and code 3 subtracts mem[S] from it. Both arithmetic results wrap modulo 2^16.
- R5: Code 1 writes the accumulator to mem[S] in one cycle with `mem_we` high. Two write cycles never occur back to back.
- R6: Code 4 always continues execution at address S.
- R7: Code 5 continues at S when the accumulator, read as a two's complement number, is zero or positive (bit 15 clear). Otherwise it falls through.
- R8: Code 6 continues at S when the accumulator is non-zero. Otherwise it falls through.
- R9: Code 7 stops the processor. `halted` then stays high and no memory write happens until reset.
- R10: Codes 8 to 15 do nothing. They neither write memory nor change the accumulator, and execution moves on to the next word.
- R11: Memory reads have one cycle of latency. Counted in rising clock edges from reset release, codes 0, 2 and 3 take 4 edges each and every other code takes 3. `halted` is seen high 3 edges after the fetch of the stop instruction begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address presented to the memory |
| mem_we | output | 1 | Write strobe for the current address |
| mem_wdata | output | 16 | Data to be written (the accumulator) |
| mem_rdata | input | 16 | Data read from the address presented on the previous edge |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The assertions assume a memory that returns, one edge later, the word at the address presented, and that holds a program which writes only through the processor's own port. They also assume that reset is applied for at least one edge before execution starts. The bench keeps to this by modelling such a memory and loading programs only while reset is held. It always ends each program with a stop instruction, so no run can wander into unwritten words. Arithmetic and branch results are then predicted from the operand values swept in the bench.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   // Low three bits of the operation code; upper code bits mark reserved codes.
   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_ADD   = 3'd2,
      OP_SUB   = 3'd3,
      OP_JUMP  = 3'd4,
      OP_JPOS  = 3'd5,
      OP_JNZ   = 3'd6,
      OP_STOP  = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      ST_FETCH = 3'd0,
      ST_LATCH = 3'd1,
      ST_EXEC  = 3'd2,
      ST_WBACK = 3'd3,
      ST_HALT  = 3'd4
   } state_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mem_in,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder; subtraction by inverted operand plus carry-in.
         logic              is_sub;
         logic [DATA_W-1:0] opnd;
         assign is_sub = (op == OP_SUB);
         assign opnd   = is_sub ? ~mem_in : mem_in;
         assign arith  = acc_in + opnd + DATA_W'(is_sub);
      end else begin : g_split
         // Separate adder and subtractor, selected afterwards.
         logic [DATA_W-1:0] plus_v;
         logic [DATA_W-1:0] minus_v;
         assign plus_v  = acc_in + mem_in;
         assign minus_v = acc_in - mem_in;
         assign arith   = (op == OP_SUB) ? minus_v : plus_v;
      end
   endgenerate

   always_comb begin
      if (op == OP_LOAD) result = mem_in;
      else               result = arith;
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             acc_neg,
   input  logic             acc_zero,
   output op_e              op,
   output logic             ir_load,
   output logic             pc_inc,
   output logic             pc_jump,
   output logic             acc_load,
   output logic             mem_write,
   output logic             sel_operand,
   output logic             halted
);

   state_e state_q, state_d;
   logic   reserved;

   assign op = op_e'(opcode[2:0]);

   generate
      if (OPC_W > 3) begin : g_rsv
         assign reserved = |opcode[OPC_W-1:3];
      end else begin : g_no_rsv
         assign reserved = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d     = state_q;
      ir_load     = 1'b0;
      pc_inc      = 1'b0;
      pc_jump     = 1'b0;
      acc_load    = 1'b0;
      mem_write   = 1'b0;
      sel_operand = 1'b0;
      unique case (state_q)
         ST_FETCH: state_d = ST_LATCH;
         ST_LATCH: begin
            ir_load = 1'b1;
            pc_inc  = 1'b1;
            state_d = ST_EXEC;
         end
         ST_EXEC: begin
            sel_operand = 1'b1;
            state_d     = ST_FETCH;
            if (!reserved) begin
               unique case (op)
                  OP_LOAD, OP_ADD, OP_SUB: state_d = ST_WBACK;
                  OP_STORE: mem_write = 1'b1;
                  OP_JUMP:  pc_jump   = 1'b1;
                  OP_JPOS:  pc_jump   = !acc_neg;
                  OP_JNZ:   pc_jump   = !acc_zero;
                  OP_STOP:  state_d   = ST_HALT;
                  default:  state_d   = ST_FETCH;
               endcase
            end
         end
         ST_WBACK: begin
            sel_operand = 1'b1;
            acc_load    = 1'b1;
            state_d     = ST_FETCH;
         end
         ST_HALT: state_d = ST_HALT;
         default: state_d = ST_FETCH;
      endcase
   end

   assign halted = (state_q == ST_HALT);

   a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_EXEC && reserved) |-> (!mem_write && !pc_jump && state_d == ST_FETCH));

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ir_load,
   input  logic              pc_inc,
   input  logic              pc_jump,
   input  logic              acc_load,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] alu_result,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] acc
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         ir  <= '0;
         acc <= '0;
      end else begin
         if (ir_load)       ir <= rdata;
         if (pc_jump)       pc <= ir[ADDR_W-1:0];
         else if (pc_inc)   pc <= pc + 1'b1;
         if (acc_load)      acc <= alu_result;
      end
   end

   a_r3_pc_advance: assert property (@(posedge clk) disable iff (rst)
      (pc_inc && !pc_jump) |=> (pc == $past(pc) + 1'b1));

   a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
      (!pc_inc && !pc_jump) |=> $stable(pc));

   a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
      !acc_load |=> $stable(acc));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 12,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);

   localparam int OPC_W = DATA_W - ADDR_W;

   generate
      if (OPC_W < 3) begin : g_bad_opc
         $error("acc_cpu: operation code field needs at least 3 bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("acc_cpu: address field must be at least 1 bit");
      end
   endgenerate

   logic              ir_load, pc_inc, pc_jump, acc_load, sel_operand;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] ir, acc, alu_y;
   op_e               op;

   acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .opcode     (ir[DATA_W-1:ADDR_W]),
      .acc_neg    (acc[DATA_W-1]),
      .acc_zero   (acc == '0),
      .op         (op),
      .ir_load    (ir_load),
      .pc_inc     (pc_inc),
      .pc_jump    (pc_jump),
      .acc_load   (acc_load),
      .mem_write  (mem_we),
      .sel_operand(sel_operand),
      .halted     (halted)
   );

   acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .ir_load   (ir_load),
      .pc_inc    (pc_inc),
      .pc_jump   (pc_jump),
      .acc_load  (acc_load),
      .rdata     (mem_rdata),
      .alu_result(alu_y),
      .pc        (pc),
      .ir        (ir),
      .acc       (acc)
   );

   acc_cpu_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op    (op),
      .acc_in(acc),
      .mem_in(mem_rdata),
      .result(alu_y)
   );

   assign mem_addr  = sel_operand ? ir[ADDR_W-1:0] : pc;
   assign mem_wdata = acc;

   a_r1_reset_restart: assert property (@(posedge clk)
      rst |=> (mem_addr == '0 && !halted && !mem_we));

   a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        halted;

   logic        tb_we = 1'b0;
   logic [11:0] tb_addr = '0;
   logic [15:0] tb_data = '0;
   logic [15:0] mem [0:4095];

   int errors = 0;
   int checks = 0;
   int ticks  = 0;

   always #2 clk = ~clk;

   acc_cpu u_acc_cpu (
      .clk      (clk),
      .rst      (rst),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .halted   (halted)
   );

   // Synchronous single-port memory model with a bench load path.
   always @(posedge clk) begin
      if (tb_we)       mem[tb_addr]  <= tb_data;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(posedge clk) begin
      ticks++;
      if (ticks >= 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000", ticks);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] w(input int op, input int s);
      return {op[3:0], s[11:0]};
   endfunction

   function automatic logic [15:0] val(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
         3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
         6: return 16'hFFFF;  7: return 16'h1234;  8: return 16'hFFFE;
         default: return 16'h00FF;
      endcase
   endfunction

   task automatic put(input int a, input logic [15:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a[11:0]; tb_data = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   // Release reset and count rising edges until halted is seen.
   task automatic run(output int cyc);
      @(negedge clk);
      rst = 1'b0;
      cyc = 0;
      while (!halted && cyc < 300) begin
         @(posedge clk); #1;
         cyc++;
      end
   endtask

   task automatic stop_run();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
   endtask

   task automatic branch_prog(input int opc, input logic [15:0] a, output int cyc);
      put(0, w(0, 'h2E)); put(1, w(opc, 4)); put(2, w(1, 'h30));
      put(3, w(7, 0));    put(4, w(1, 'h31)); put(5, w(7, 0));
      put('h2E, a); put('h30, ~a); put('h31, ~a);
      run(cyc);
      stop_run();
   endtask

   initial begin
      int cyc;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!halted && !mem_we && mem_addr == 0, "R1 reset outputs",
          {halted, mem_we, mem_addr}, 0);

      // R3 R4 R11: add sweep
      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 10; j++) begin
            put(0, w(0, 'h2E)); put(1, w(2, 'h2F)); put(2, w(1, 'h30)); put(3, w(7, 0));
            put('h2E, val(i)); put('h2F, val(j)); put('h30, 16'hDEAD);
            run(cyc);
            chk(mem['h30] == 16'(val(i) + val(j)), "R4 add result", mem['h30], 16'(val(i) + val(j)));
            chk(cyc == 14, "R11 add program edges", cyc, 14);
            if (i == 3 && j == 1) begin
               // R9: halt holds, no writes
               for (int k = 0; k < 20; k++) begin
                  @(negedge clk);
                  chk(halted && !mem_we, "R9 halt holds", {halted, mem_we}, 2);
               end
               chk(mem['h30] == 16'h8000, "R9 memory untouched", mem['h30], 16'h8000);
            end
            stop_run();
         end
      end

      // R4: subtract sweep
      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 10; j++) begin
            put(0, w(0, 'h2E)); put(1, w(3, 'h2F)); put(2, w(1, 'h30)); put(3, w(7, 0));
            put('h2E, val(i)); put('h2F, val(j)); put('h30, 16'hDEAD);
            run(cyc);
            chk(mem['h30] == 16'(val(i) - val(j)), "R4 sub result", mem['h30], 16'(val(i) - val(j)));
            stop_run();
         end
      end

      // R1: accumulator cleared by reset (previous A nonzero)
      put(0, w(1, 'h30)); put(1, w(7, 0)); put('h30, 16'h1234);
      run(cyc);
      chk(mem['h30] == 16'h0000, "R1 accumulator reset", mem['h30], 0);
      chk(cyc == 6, "R11 store program edges", cyc, 6);
      stop_run();

      // R1: reset mid-run restarts at word 0
      put(0, w(0, 'h2E)); put(1, w(2, 'h2F)); put(2, w(1, 'h30)); put(3, w(7, 0));
      put('h2E, 16'h0010); put('h2F, 16'h0020); put('h30, 16'h0000);
      @(negedge clk); rst = 1'b0;
      repeat (6) @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      chk(mem_addr == 0 && !halted && !mem_we, "R1 mid-run reset", mem_addr, 0);
      run(cyc);
      chk(mem['h30] == 16'h0030, "R1 restart result", mem['h30], 16'h0030);
      stop_run();

      // R6: unconditional jump skips a store
      for (int i = 0; i < 10; i++) begin
         put(0, w(0, 'h2E)); put(1, w(4, 3)); put(2, w(1, 'h31));
         put(3, w(1, 'h30)); put(4, w(7, 0));
         put('h2E, val(i)); put('h30, ~val(i)); put('h31, ~val(i));
         run(cyc);
         chk(mem['h30] == val(i) && mem['h31] == ~val(i), "R6 jump taken", mem['h31], ~val(i));
         chk(cyc == 13, "R11 jump program edges", cyc, 13);
         stop_run();
      end

      // R7 R8: conditional jumps
      for (int i = 0; i < 10; i++) begin
         bit tk;
         branch_prog(5, val(i), cyc);
         tk = !val(i)[15];
         chk(tk ? (mem['h31] == val(i) && mem['h30] == ~val(i))
                : (mem['h30] == val(i) && mem['h31] == ~val(i)),
             "R7 jump if non-negative", mem['h31], tk ? val(i) : ~val(i));
         chk(cyc == 13, "R11 branch edges", cyc, 13);
         branch_prog(6, val(i), cyc);
         tk = (val(i) != 0);
         chk(tk ? (mem['h31] == val(i) && mem['h30] == ~val(i))
                : (mem['h30] == val(i) && mem['h31] == ~val(i)),
             "R8 jump if non-zero", mem['h31], tk ? val(i) : ~val(i));
      end

      // R10: reserved codes are no-ops
      for (int op = 8; op < 16; op++) begin
         put(0, w(0, 'h2E)); put(1, w(op, 'h30)); put(2, w(1, 'h31)); put(3, w(7, 0));
         put('h2E, 16'h4321); put('h30, 16'hBCDE); put('h31, 16'hBCDE);
         run(cyc);
         chk(mem['h30] == 16'hBCDE, "R10 reserved no write", mem['h30], 16'hBCDE);
         chk(mem['h31] == 16'h4321, "R10 accumulator kept", mem['h31], 16'h4321);
         chk(cyc == 13, "R10 reserved timing", cyc, 13);
         stop_run();
      end

      // R2: top of the address space
      put(0, w(0, 'hFFF)); put(1, w(1, 'hFFE)); put(2, w(7, 0));
      put('hFFF, 16'hBEEF); put('hFFE, 16'h0000);
      run(cyc);
      chk(mem['hFFE] == 16'hBEEF, "R2 highest operand address", mem['hFFE], 16'hBEEF);
      chk(cyc == 10, "R11 load-store edges", cyc, 10);
      stop_run();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule